// File: doc/BRIEF.md
# Legacy Audio I/O Window Decoder

This block watches host I/O cycles and decides which of four legacy audio sub-blocks, if any, claims each one. The four targets are a sound-card-compatible block, an FM synthesizer, an MPU-401 MIDI port and a joystick port. Each target has its own 16-bit base address and its own enable bit. A global legacy-disable input switches all decoding off. A mode bit picks between 10-bit aliased decode and full 16-bit decode.

The FM synthesizer can also be reached through a sub-range of the sound-card window. This path works whenever the sound-card window is claimed, whatever the FM enable bit says. The block also gates the MPU-401 interrupt enable, and it turns each received MIDI byte strobe into a one-cycle interrupt request when that enable is in effect.

A small state machine registers the result of each cycle. It has three states:
- `ST_IDLE`: no cycle was presented.
- `ST_HIT`: a window claimed the cycle.
- `ST_MISS`: a cycle was presented and no window claimed it.

From any state, the next state is chosen every clock:
- idle→idle, hit→idle and miss→idle when `io_valid_i` is low.
- any→hit when a window matches.
- any→miss when `io_valid_i` is high and nothing matches.

Top module: `legio_decoder`

## Requirements
- R1: While `lad_i` is 1, no window claims a cycle: `sel_o`, `fm_access_o` and `claim_o` stay 0, and `mpu_irq_en_o` is 0.
- R2: Window enables come from `ctrl_i`: bit 0 enables the sound-card window, bit 1 the FM window, bit 2 the joystick window and bit 3 the MPU-401 window. A window whose bit is 0 never claims a cycle.
- R3: Window sizes are 16 bytes (sound-card), 4 (FM), 2 (MPU-401) and 1 (joystick). A cycle hits when the address matches the base in every compared bit above the window's offset bits. Base bits inside the offset range are ignored.
- R4: When `ctrl_i` bit 5 is 1, only address bits [9:0] are compared. When it is 0, all 16 bits are compared.
- R5: `fm_access_o` is 1 when the FM window is selected. It is also 1 when the sound-card window is selected at offset 0–3 or 8–9, and in that case the FM enable bit has no effect.
- R6: `sel_o` is one-hot or zero, with bit 0 for sound-card, bit 1 for FM, bit 2 for MPU-401 and bit 3 for joystick. When windows overlap, priority runs sound-card, then FM, then MPU-401, then joystick.
- R7: `mpu_irq_en_o` equals `ctrl_i` bit 4, but only while `lad_i` is 0 and `ctrl_i` bit 3 is 1; otherwise it is 0.
- R8: A pulse on `midi_rx_i` gives a one-cycle `mpu_irq_o` in the next cycle, but only if `mpu_irq_en_o` was 1 at that time.
- R9: Results are registered one clock after `io_valid_i` is sampled. `claim_o` is 1 exactly in `ST_HIT`. All outputs are 0 after reset and after a cycle with `io_valid_i` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_valid_i | input | 1 | Host I/O cycle present |
| io_addr_i | input | 16 | Host I/O address |
| lad_i | input | 1 | Global legacy disable |
| ctrl_i | input | 6 | Enables [3:0], MPU interrupt enable [4], alias mode [5] |
| base_sb_i | input | 16 | Sound-card window base |
| base_fm_i | input | 16 | FM window base |
| base_mpu_i | input | 16 | MPU-401 window base |
| base_joy_i | input | 16 | Joystick window base |
| midi_rx_i | input | 1 | Received MIDI byte strobe |
| sel_o | output | 4 | One-hot window select |
| fm_access_o | output | 1 | Cycle reaches the FM synthesizer |
| claim_o | output | 1 | Cycle claimed |
| mpu_irq_en_o | output | 1 | Effective MPU interrupt enable |
| mpu_irq_o | output | 1 | MPU interrupt request pulse |

## Verification
Two functions can fall in the same cycle here.

The first pair is a sound-card select and an FM access. The bench provokes this by addressing the FM alias offsets of the sound-card window, both with the FM enable cleared and with the FM base placed inside the sound-card window. The check requires `sel_o` to show only the sound-card bit while `fm_access_o` rises alongside it.

The second pair is overlapping windows from different targets matching at once. The bench provokes this by moving bases on top of one another. The check requires the higher-priority target alone to appear on `sel_o`.

// File: rtl/legio_pkg.sv
package legio_pkg;
    localparam int ADDR_W  = 16;
    localparam int ALIAS_W = 10;
    localparam int NUM_WIN = 4;
    localparam int CTRL_W  = 6;

    localparam int W_SB  = 0;
    localparam int W_FM  = 1;
    localparam int W_MPU = 2;
    localparam int W_JOY = 3;

    localparam int C_EN_SB  = 0;
    localparam int C_EN_FM  = 1;
    localparam int C_EN_JOY = 2;
    localparam int C_EN_MPU = 3;
    localparam int C_IRQEN  = 4;
    localparam int C_ALIAS  = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HIT  = 2'd1,
        ST_MISS = 2'd2
    } legio_state_e;

    function automatic int win_span_lg(input int w);
        case (w)
            W_SB:    return 4;
            W_FM:    return 2;
            W_MPU:   return 1;
            default: return 0;
        endcase
    endfunction
endpackage

// File: rtl/legio_window_match.sv
module legio_window_match #(
    parameter int ADDR_W  = 16,
    parameter int ALIAS_W = 10,
    parameter int SPAN_LG = 0
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic              en_i,
    input  logic              lad_i,
    input  logic              alias_i,
    output logic              hit_o
);
    logic [ADDR_W-1:0] keep;

    genvar b;
    generate
        for (b = 0; b < ADDR_W; b++) begin : g_bit
            if (b < SPAN_LG) begin : g_off
                assign keep[b] = 1'b0;
            end else if (b < ALIAS_W) begin : g_low
                assign keep[b] = 1'b1;
            end else begin : g_high
                assign keep[b] = ~alias_i;
            end
        end
    endgenerate

    assign hit_o = en_i && !lad_i && (((addr_i ^ base_i) & keep) == '0);
endmodule

// File: rtl/legio_prio_sel.sv
module legio_prio_sel #(
    parameter int N = 4
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                gnt_o[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/legio_decoder.sv
module legio_decoder
    import legio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic              lad_i,
    input  logic [CTRL_W-1:0] ctrl_i,
    input  logic [ADDR_W-1:0] base_sb_i,
    input  logic [ADDR_W-1:0] base_fm_i,
    input  logic [ADDR_W-1:0] base_mpu_i,
    input  logic [ADDR_W-1:0] base_joy_i,
    input  logic              midi_rx_i,
    output logic [NUM_WIN-1:0] sel_o,
    output logic              fm_access_o,
    output logic              claim_o,
    output logic              mpu_irq_en_o,
    output logic              mpu_irq_o
);
    logic [NUM_WIN-1:0][ADDR_W-1:0] bases;
    logic [NUM_WIN-1:0]             win_en;
    logic [NUM_WIN-1:0]             hit;
    logic [NUM_WIN-1:0]             gnt;
    logic                           alias_sub;
    legio_state_e                   state_q, state_d;
    logic [NUM_WIN-1:0]             sel_q;
    logic                           fm_acc_q;
    logic                           irq_q;

    assign bases[W_SB]   = base_sb_i;
    assign bases[W_FM]   = base_fm_i;
    assign bases[W_MPU]  = base_mpu_i;
    assign bases[W_JOY]  = base_joy_i;
    assign win_en[W_SB]  = ctrl_i[C_EN_SB];
    assign win_en[W_FM]  = ctrl_i[C_EN_FM];
    assign win_en[W_MPU] = ctrl_i[C_EN_MPU];
    assign win_en[W_JOY] = ctrl_i[C_EN_JOY];

    genvar w;
    generate
        for (w = 0; w < NUM_WIN; w++) begin : g_win
            legio_window_match #(
                .ADDR_W (ADDR_W),
                .ALIAS_W(ALIAS_W),
                .SPAN_LG(win_span_lg(w))
            ) u_match (
                .addr_i (io_addr_i),
                .base_i (bases[w]),
                .en_i   (win_en[w]),
                .lad_i  (lad_i),
                .alias_i(ctrl_i[C_ALIAS]),
                .hit_o  (hit[w])
            );
        end
    endgenerate

    legio_prio_sel #(.N(NUM_WIN)) u_prio (
        .req_i(hit),
        .gnt_o(gnt)
    );

    // FM register alias offsets inside the sound-card window
    always_comb begin
        unique case (io_addr_i[3:0])
            4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9: alias_sub = 1'b1;
            default:                            alias_sub = 1'b0;
        endcase
    end

    always_comb begin
        if (!io_valid_i) begin
            state_d = ST_IDLE;
        end else if (|hit) begin
            state_d = ST_HIT;
        end else begin
            state_d = ST_MISS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            fm_acc_q <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            unique case (state_d)
                ST_HIT: begin
                    sel_q    <= gnt;
                    fm_acc_q <= gnt[W_FM] | (gnt[W_SB] & alias_sub);
                end
                ST_IDLE, ST_MISS: begin
                    sel_q    <= '0;
                    fm_acc_q <= 1'b0;
                end
                default: begin
                    sel_q    <= '0;
                    fm_acc_q <= 1'b0;
                end
            endcase
            irq_q <= midi_rx_i & mpu_irq_en_o;
        end
    end

    assign mpu_irq_en_o = !lad_i && ctrl_i[C_EN_MPU] && ctrl_i[C_IRQEN];
    assign sel_o        = sel_q;
    assign fm_access_o  = fm_acc_q;
    assign claim_o      = (state_q == ST_HIT);
    assign mpu_irq_o    = irq_q;
endmodule

// File: rtl/legio_decoder_chk.sv
module legio_decoder_chk
    import legio_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               io_valid_i,
    input logic               lad_i,
    input logic [NUM_WIN-1:0] sel_o,
    input logic               fm_access_o,
    input logic               claim_o,
    input logic               mpu_irq_en_o,
    input logic               mpu_irq_o
);
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    p_lad_block_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lad_i |=> (sel_o == '0) && !fm_access_o && !claim_o);

    p_fm_alias_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fm_access_o && !sel_o[W_FM]) |-> sel_o[W_SB]);

    p_claim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o == (sel_o != '0));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid_i |=> !claim_o && !fm_access_o);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !mpu_irq_en_o |=> !mpu_irq_o);
endmodule

bind legio_decoder legio_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_valid_i  (io_valid_i),
    .lad_i       (lad_i),
    .sel_o       (sel_o),
    .fm_access_o (fm_access_o),
    .claim_o     (claim_o),
    .mpu_irq_en_o(mpu_irq_en_o),
    .mpu_irq_o   (mpu_irq_o)
);

// File: tb/sim_legio_decoder.sv
module sim_legio_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_valid_i = 1'b0;
    logic [15:0] io_addr_i = '0;
    logic        lad_i = 1'b0;
    logic [5:0]  ctrl_i = 6'h3F;
    logic [15:0] base_sb_i = 16'h0220;
    logic [15:0] base_fm_i = 16'h0388;
    logic [15:0] base_mpu_i = 16'h0330;
    logic [15:0] base_joy_i = 16'h0201;
    logic        midi_rx_i = 1'b0;
    logic [3:0]  sel_o;
    logic        fm_access_o, claim_o, mpu_irq_en_o, mpu_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    legio_decoder u0 (
        .clk(clk), .rst_n(rst_n), .io_valid_i(io_valid_i), .io_addr_i(io_addr_i),
        .lad_i(lad_i), .ctrl_i(ctrl_i), .base_sb_i(base_sb_i), .base_fm_i(base_fm_i),
        .base_mpu_i(base_mpu_i), .base_joy_i(base_joy_i), .midi_rx_i(midi_rx_i),
        .sel_o(sel_o), .fm_access_o(fm_access_o), .claim_o(claim_o),
        .mpu_irq_en_o(mpu_irq_en_o), .mpu_irq_o(mpu_irq_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one cycle, sample the registered result one clock later
    task automatic cyc(input string req, input logic [15:0] a,
                       input logic [3:0] es, input logic ef);
        @(negedge clk);
        io_valid_i = 1'b1;
        io_addr_i  = a;
        @(negedge clk);
        io_valid_i = 1'b0;
        check(req, {2'b0, claim_o, ef ? 1'b1 : 1'b0, sel_o} & 8'h3F,
                   {2'b0, (es != 0), ef, es});
        if (fm_access_o !== ef) begin
            checks++; fails++;
            $display("FAIL %s fm_access actual=%b expected=%b", req, fm_access_o, ef);
        end
    endtask

    task automatic t_reset();
        check("R9 reset", {3'b0, claim_o, fm_access_o, mpu_irq_o, sel_o == 0, 1'b0}, 8'h02);
        @(negedge clk);
        check("R9 idle", {4'b0, sel_o}, 8'h00);
    endtask

    task automatic t_basic();
        cyc("R3 sb offC", 16'h022C, 4'b0001, 1'b0);
        cyc("R3 fm", 16'h038A, 4'b0010, 1'b1);
        cyc("R3 mpu", 16'h0331, 4'b0100, 1'b0);
        cyc("R3 joy", 16'h0201, 4'b1000, 1'b0);
        cyc("R3 joy miss", 16'h0202, 4'b0000, 1'b0);
        cyc("R3 mpu miss", 16'h0332, 4'b0000, 1'b0);
        cyc("R3 miss", 16'h0300, 4'b0000, 1'b0);
    endtask

    task automatic t_alias();
        cyc("R4 alias10 hit", 16'h1220, 4'b0001, 1'b1);
        ctrl_i[5] = 1'b0;
        cyc("R4 full16 miss", 16'h1220, 4'b0000, 1'b0);
        cyc("R4 full16 hit", 16'h0225, 4'b0001, 1'b0);
        ctrl_i[5] = 1'b1;
    endtask

    task automatic t_enables();
        ctrl_i[1] = 1'b0;
        cyc("R2 fm off", 16'h0388, 4'b0000, 1'b0);
        cyc("R5 alias via sb fm off", 16'h0228, 4'b0001, 1'b1);
        cyc("R5 non-alias off", 16'h0224, 4'b0001, 1'b0);
        ctrl_i[1] = 1'b1;
        ctrl_i[0] = 1'b0;
        cyc("R2 sb off", 16'h0221, 4'b0000, 1'b0);
        ctrl_i[0] = 1'b1;
        ctrl_i[2] = 1'b0;
        cyc("R2 joy off", 16'h0201, 4'b0000, 1'b0);
        ctrl_i[2] = 1'b1;
        ctrl_i[3] = 1'b0;
        cyc("R2 mpu off", 16'h0330, 4'b0000, 1'b0);
        ctrl_i[3] = 1'b1;
    endtask

    task automatic t_lad();
        lad_i = 1'b1;
        #1 check("R1 irq_en gated", {7'b0, mpu_irq_en_o}, 8'h00);
        cyc("R1 sb blocked", 16'h0220, 4'b0000, 1'b0);
        cyc("R1 fm blocked", 16'h0388, 4'b0000, 1'b0);
        lad_i = 1'b0;
    endtask

    task automatic t_priority();
        base_fm_i = 16'h0220;
        cyc("R6 sb over fm", 16'h0222, 4'b0001, 1'b1);
        base_fm_i = 16'h0388;
        base_mpu_i = 16'h0388;
        cyc("R6 fm over mpu", 16'h0389, 4'b0010, 1'b1);
        base_mpu_i = 16'h0330;
        base_joy_i = 16'h0330;
        cyc("R6 mpu over joy", 16'h0330, 4'b0100, 1'b0);
        base_joy_i = 16'h0201;
    endtask

    task automatic t_irq();
        @(negedge clk);
        #1 check("R7 en on", {7'b0, mpu_irq_en_o}, 8'h01);
        midi_rx_i = 1'b1;
        @(negedge clk);
        midi_rx_i = 1'b0;
        check("R8 irq pulse", {7'b0, mpu_irq_o}, 8'h01);
        @(negedge clk);
        check("R8 irq one cycle", {7'b0, mpu_irq_o}, 8'h00);
        ctrl_i[4] = 1'b0;
        #1 check("R7 irq bit off", {7'b0, mpu_irq_en_o}, 8'h00);
        midi_rx_i = 1'b1;
        @(negedge clk);
        midi_rx_i = 1'b0;
        check("R8 no irq", {7'b0, mpu_irq_o}, 8'h00);
        ctrl_i[4] = 1'b1;
        ctrl_i[3] = 1'b0;
        #1 check("R7 mpu off", {7'b0, mpu_irq_en_o}, 8'h00);
        ctrl_i[3] = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #35 rst_n = 1'b1;
        t_reset();
        t_basic();
        t_alias();
        t_enables();
        t_lad();
        t_priority();
        t_irq();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule